// File: doc/BRIEF.md
# Interrupt Redirection Register Block

This block holds the programmable state of an I/O interrupt router with 24 input lines. Software never addresses the internal registers directly. It writes an 8-bit selector at bus offset 0x00 and then reads or writes the chosen register through a 32-bit data window at bus offset 0x10. Behind the window sit a 4-bit router identifier, a fixed version word, and one 64-bit redirection entry per input line. Each entry is reached as a low half and a high half.

The delivery logic sees every entry on a flat output bus. It gets a one-cycle strobe with the entry number each time software changes an entry. It owns the remote-IRR flag of each entry through per-entry set and clear inputs. Software cannot overwrite the hardware-owned delivery-status and remote-IRR bits. Programming an entry to edge mode drops any remote-IRR flag left from earlier level-mode use.

Top module: `irq_redir_regs`

## Requirements
- R1: A bus write to offset 0x00 stores data bits 7:0 as the selector, for any access size. A read of offset 0x00 returns the selector in bits 7:0 and zero in bits 31:8.
- R2: Offset 0x04 reads as zero and a write to it leaves the selector unchanged. Any bus offset other than 0x00 and 0x10 reads as zero.
- R3: Selector 0x00 is the identifier. A window write stores data bits 27:24, and a read returns them in bits 27:24 with every other bit zero. Selector 0x02 reads the same value, and writes through it are discarded.
- R4: Selector 0x01 always reads 0x00170011, and writes through it are discarded.
- R5: Selector 0x10+2n reaches bits 31:0 of entry n and selector 0x11+2n reaches bits 63:32, for n from 0 to 23. The high half is fully writable and reads back as written.
- R6: Low-half bit layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 (1 = level), mask 16. A low-half write keeps the old values of bits 12 and 14 when bit 15 is written as 1.
- R7: A low-half write with bit 15 = 0 (edge) clears remote IRR. This takes priority over a hardware set in the same cycle.
- R8: Selectors 0x03 to 0x0F read as zero, and writes through them change no state and raise no strobe.
- R9: Selectors that decode past entry 23 (0x40 and up) read as 0xFFFFFFFF, and writes through them change no entry and raise no strobe.
- R10: After reset the selector and identifier are zero, and each entry reads 0x00010000 in its low half (only the mask set) and zero in its high half.
- R11: A window write flagged as not a full 32-bit access (busFull = 0) is discarded.
- R12: Each accepted entry write raises cfgWr for exactly one cycle. The pulse starts on the clock edge that updates the entry, and cfgIdx holds the entry number. Both halves produce the pulse.
- R13: irrSet[n] sets the remote IRR of entry n and irrClr[n] clears it. When both are high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Bus byte offset |
| busWr | input | 1 | Bus write request |
| busFull | input | 1 | Write covers all 32 bits |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irrSet | input | 24 | Per-entry remote-IRR set from delivery logic |
| irrClr | input | 24 | Per-entry remote-IRR clear from delivery logic |
| entries | output | 1536 | All entries, entry n at bits 64n+63:64n |
| cfgWr | output | 1 | One-cycle pulse on accepted entry write |
| cfgIdx | output | 5 | Entry number for cfgWr |

## Verification
The hardest case to reach is a collision between hardware and software on one remote-IRR flag. An edge-mode low-half write and an irrSet pulse must land in the same clock cycle. The stimulus first loads the selector with a separate write. It then drives the window write and the set pulse together on one edge, and reads back the low half to confirm the flag is clear. Set-versus-clear collisions and reads after a preserving level-mode write cover the other orderings.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int SEL_W  = 8;
  localparam int SLOT_W = 7;   // enough for any slot an 8-bit selector decodes

  localparam int BIT_STATUS = 12;
  localparam int BIT_IRR    = 14;
  localparam int BIT_TRIG   = 15;
  localparam int BIT_MASK   = 16;

  localparam logic [SEL_W-1:0] OFF_SEL   = 8'h00;
  localparam logic [SEL_W-1:0] OFF_PAD   = 8'h04;
  localparam logic [SEL_W-1:0] OFF_WIN   = 8'h10;
  localparam logic [SEL_W-1:0] SEL_ID    = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER   = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB   = 8'h02;
  localparam logic [SEL_W-1:0] SEL_ENTRY = 8'h10;

  typedef struct packed {
    logic              idWr;
    logic              loWr;
    logic              hiWr;
    logic              hiHalf;
    logic [SLOT_W-1:0] slot;
  } regStrobe_t;
endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [31:0] VERSION     = 32'h00170011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] busAddr,
  input  logic             busWr,
  input  logic             busFull,
  input  logic [SEL_W-1:0] selWdata,
  input  logic [3:0]       idVal,
  input  logic [31:0]      entWord,
  output regStrobe_t       strb,
  output logic [31:0]      busRdata
);
  localparam int LAST_SEL = 16 + 2 * NUM_ENTRIES;

  logic [SEL_W-1:0] selQ;
  logic [SEL_W-1:0] entOff;
  logic             inEntries;
  logic             slotOk;
  logic             winWrOk;
  logic [31:0]      winData;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else if (busWr && busAddr == OFF_SEL) selQ <= selWdata;
  end

  assign entOff    = selQ - SEL_ENTRY;
  assign inEntries = selQ >= SEL_ENTRY;
  assign slotOk    = inEntries && (int'(entOff[SEL_W-1:1]) < NUM_ENTRIES);
  assign winWrOk   = busWr && busFull && busAddr == OFF_WIN;

  always_comb begin
    strb        = '0;
    strb.slot   = entOff[SEL_W-1:1];
    strb.hiHalf = entOff[0];
    strb.idWr   = winWrOk && selQ == SEL_ID;
    strb.loWr   = winWrOk && slotOk && !entOff[0];
    strb.hiWr   = winWrOk && slotOk &&  entOff[0];
  end

  always_comb begin
    if (selQ == SEL_ID || selQ == SEL_ARB) winData = {4'b0, idVal, 24'b0};
    else if (selQ == SEL_VER)              winData = VERSION;
    else if (slotOk)                       winData = entWord;
    else if (inEntries)                    winData = '1;
    else                                   winData = '0;
  end

  always_comb begin
    unique case (busAddr)
      OFF_SEL: busRdata = {24'b0, selQ};
      OFF_WIN: busRdata = winData;
      default: busRdata = '0;
    endcase
  end

  a_r1_sel_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == OFF_SEL |-> busRdata[31:8] == '0);
  a_r9_no_strobe_oob: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_WIN && int'(selQ) >= LAST_SEL) |-> !(strb.loWr || strb.hiWr));
  a_r11_partial_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busFull) |-> !(strb.idWr || strb.loWr || strb.hiWr));
  a_r8_gap_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && selQ > SEL_ARB && selQ < SEL_ENTRY) |-> !(strb.idWr || strb.loWr || strb.hiWr));
endmodule

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strb,
  input  logic [31:0]                  wdata,
  input  logic [NUM_ENTRIES-1:0]       irrSet,
  input  logic [NUM_ENTRIES-1:0]       irrClr,
  output logic [3:0]                   idVal,
  output logic [31:0]                  entWord,
  output logic [NUM_ENTRIES*64-1:0]    entries,
  output logic                         cfgWr,
  output logic [$clog2(NUM_ENTRIES)-1:0] cfgIdx
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [31:0] LO_RESET = 32'h1 << BIT_MASK;

  logic [31:0] loQ [NUM_ENTRIES];
  logic [31:0] hiQ [NUM_ENTRIES];
  logic [31:0] loView [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] irrQ;
  logic [NUM_ENTRIES-1:0] statVec;
  logic [3:0]  idQ;
  logic        cfgWrQ;
  logic [IDX_W-1:0] cfgIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) idQ <= '0;
    else if (strb.idWr) idQ <= wdata[27:24];
  end
  assign idVal = idQ;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic loHit, hiHit, irrNext;
    assign loHit = strb.loWr && strb.slot == SLOT_W'(i);
    assign hiHit = strb.hiWr && strb.slot == SLOT_W'(i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ[i] <= LO_RESET;
        hiQ[i] <= '0;
      end else begin
        if (loHit) loQ[i] <= {wdata[31:BIT_TRIG], 1'b0, wdata[BIT_IRR-1],
                              loQ[i][BIT_STATUS], wdata[BIT_STATUS-1:0]};
        if (hiHit) hiQ[i] <= wdata;
      end
    end

    always_comb begin
      irrNext = irrQ[i];
      if (irrClr[i]) irrNext = 1'b0;
      if (irrSet[i]) irrNext = 1'b1;
      if (loHit && !wdata[BIT_TRIG]) irrNext = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) irrQ[i] <= 1'b0;
      else       irrQ[i] <= irrNext;
    end

    assign loView[i]  = {loQ[i][31:BIT_TRIG], irrQ[i], loQ[i][BIT_IRR-1:0]};
    assign statVec[i] = loQ[i][BIT_STATUS];
    assign entries[i*64 +: 64] = {hiQ[i], loView[i]};

    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (irrSet[i] && !(loHit && !wdata[BIT_TRIG])) |=> irrQ[i]);
  end

  always_comb begin
    entWord = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (strb.slot == SLOT_W'(i)) entWord = strb.hiHalf ? hiQ[i] : loView[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWrQ  <= 1'b0;
      cfgIdxQ <= '0;
    end else begin
      cfgWrQ  <= strb.loWr || strb.hiWr;
      cfgIdxQ <= strb.slot[IDX_W-1:0];
    end
  end
  assign cfgWr  = cfgWrQ;
  assign cfgIdx = cfgIdxQ;

  a_r7_edge_clears_irr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loWr && !wdata[BIT_TRIG]) |=> !irrQ[cfgIdxQ]);
  a_r6_status_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.loWr |=> $stable(statVec));
  a_r12_cfg_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrQ |-> int'(cfgIdxQ) < NUM_ENTRIES);
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [31:0] VERSION     = 32'h00170011
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [7:0]                     busAddr,
  input  logic                           busWr,
  input  logic                           busFull,
  input  logic [31:0]                    busWdata,
  output logic [31:0]                    busRdata,
  input  logic [NUM_ENTRIES-1:0]         irrSet,
  input  logic [NUM_ENTRIES-1:0]         irrClr,
  output logic [NUM_ENTRIES*64-1:0]      entries,
  output logic                           cfgWr,
  output logic [$clog2(NUM_ENTRIES)-1:0] cfgIdx
);
  regStrobe_t  strb;
  logic [3:0]  idVal;
  logic [31:0] entWord;

  irq_redir_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busFull(busFull),
    .selWdata(busWdata[7:0]), .idVal(idVal), .entWord(entWord),
    .strb(strb), .busRdata(busRdata));

  irq_redir_dp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .irrSet(irrSet), .irrClr(irrClr), .idVal(idVal), .entWord(entWord),
    .entries(entries), .cfgWr(cfgWr), .cfgIdx(cfgIdx));
endmodule

// File: tb/test_irq_redir_regs.sv
module test_irq_redir_regs;
  localparam int N = 24;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] busAddr = 0;
  logic busWr = 0, busFull = 1;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [N-1:0] irrSet = 0, irrClr = 0;
  logic [N*64-1:0] entries;
  logic cfgWr;
  logic [4:0] cfgIdx;
  logic rdPend = 0;

  int nVec = 0, nBad = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic [N*64-1:0] saved;

  always #2.5 clk = ~clk;

  irq_redir_regs i_irq_redir_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busFull(busFull),
    .busWdata(busWdata), .busRdata(busRdata), .irrSet(irrSet), .irrClr(irrClr),
    .entries(entries), .cfgWr(cfgWr), .cfgIdx(cfgIdx));

  // monitor: pops expected read data as each read cycle completes
  always @(negedge clk) begin
    if (rdPend) begin
      logic [31:0] e;
      string t;
      nVec++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL scoreboard empty: actual %h expected none", busRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          nBad++;
          $display("FAIL %s: actual %h expected %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic full);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busFull = full; busWr = 1;
    @(posedge clk); #1;
    busWr = 0; busFull = 1;
  endtask

  task automatic readExp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busAddr = a; rdPend = 1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); #1;
    rdPend = 0;
  endtask

  task automatic winWr(input logic [7:0] s, input logic [31:0] d, input logic full);
    busWrite(8'h00, {24'b0, s}, 1);
    busWrite(8'h10, d, full);
  endtask

  task automatic winRd(input logic [7:0] s, input logic [31:0] e, input string tag);
    busWrite(8'h00, {24'b0, s}, 1);
    readExp(8'h10, e, tag);
  endtask

  task automatic pulseIrr(input logic [N-1:0] s, input logic [N-1:0] c);
    @(posedge clk); #1; irrSet = s; irrClr = c;
    @(posedge clk); #1; irrSet = 0; irrClr = 0;
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R10 reset state
    readExp(8'h00, 32'h0, "R10 selector");
    chk(entries[5*64 +: 64], 64'h0000_0000_0001_0000, "R10 entry5 port");
    winRd(8'h00, 32'h0, "R10 id");
    winRd(8'h10, 32'h0001_0000, "R10 entry0 lo");
    winRd(8'h11, 32'h0, "R10 entry0 hi");
    winRd(8'h3E, 32'h0001_0000, "R10 entry23 lo");

    // R1 selector
    busWrite(8'h00, 32'hABCD_12F0, 1);
    readExp(8'h00, 32'h0000_00F0, "R1 selector upper zero");
    busWrite(8'h00, 32'h0000_0033, 0);
    readExp(8'h00, 32'h0000_0033, "R1 selector partial write");

    // R2 pad offset and unmapped offsets
    busWrite(8'h04, 32'h0000_0055, 1);
    readExp(8'h00, 32'h0000_0033, "R2 pad write ignored");
    readExp(8'h04, 32'h0, "R2 pad reads zero");
    readExp(8'h20, 32'h0, "R2 unmapped offset");

    // R4 version
    winRd(8'h01, 32'h0017_0011, "R4 version");
    winWr(8'h01, 32'hFFE8_FFEE, 1);
    winRd(8'h01, 32'h0017_0011, "R4 version write ignored");

    // R3 identifier
    winWr(8'h00, 32'h1F3E_5D7C, 1);
    winRd(8'h00, 32'h0F00_0000, "R3 id bits");
    winRd(8'h02, 32'h0F00_0000, "R3 mirror");
    winWr(8'h02, 32'h0, 1);
    winRd(8'h00, 32'h0F00_0000, "R3 mirror write ignored");

    // R5 / R12 entry 5 low and high
    winWr(8'h1A, 32'h0000_965F, 1);
    chk({63'b0, cfgWr}, 64'd1, "R12 strobe high");
    chk({59'b0, cfgIdx}, 64'd5, "R12 strobe index");
    @(posedge clk); #1;
    chk({63'b0, cfgWr}, 64'd0, "R12 strobe one cycle");
    winRd(8'h1A, 32'h0000_865F, "R6 status not writable");
    winWr(8'h1B, 32'h3A00_1234, 1);
    chk({63'b0, cfgWr}, 64'd1, "R12 strobe on high half");
    winRd(8'h1B, 32'h3A00_1234, "R5 high half");
    chk(entries[5*64 +: 64], 64'h3A00_1234_0000_865F, "R5 entry5 port");

    // R13 hardware remote IRR
    pulseIrr(N'(1) << 5, '0);
    winRd(8'h1A, 32'h0000_C65F, "R13 set");
    pulseIrr('0, N'(1) << 5);
    winRd(8'h1A, 32'h0000_865F, "R13 clear");
    pulseIrr(N'(1) << 5, N'(1) << 5);
    winRd(8'h1A, 32'h0000_C65F, "R13 set wins over clear");

    // R6 level write keeps remote IRR
    winWr(8'h1A, 32'h0000_805F, 1);
    winRd(8'h1A, 32'h0000_C05F, "R6 irr kept on level write");

    // R7 edge write clears irr even with a same-cycle set
    busWrite(8'h00, 32'h1A, 1);
    @(posedge clk); #1;
    busAddr = 8'h10; busWdata = 32'h0000_005F; busWr = 1; irrSet = N'(1) << 5;
    @(posedge clk); #1;
    busWr = 0; irrSet = 0;
    winRd(8'h1A, 32'h0000_005F, "R7 edge clears irr over set");

    // R8 gap selectors
    winWr(8'h07, 32'hFFFF_FFFF, 1);
    chk({63'b0, cfgWr}, 64'd0, "R8 no strobe");
    winRd(8'h07, 32'h0, "R8 gap reads zero");
    winRd(8'h00, 32'h0F00_0000, "R8 id untouched");
    winRd(8'h10, 32'h0001_0000, "R8 entry0 untouched");

    // R9 past last entry
    saved = entries;
    winWr(8'h40, 32'h0, 1);
    chk({63'b0, cfgWr}, 64'd0, "R9 no strobe");
    chk(64'(entries == saved), 64'd1, "R9 entries unchanged");
    winRd(8'h40, 32'hFFFF_FFFF, "R9 first invalid");
    winRd(8'hFF, 32'hFFFF_FFFF, "R9 last selector");

    // R11 partial window writes
    winWr(8'h1D, 32'hDEAD_BEEF, 0);
    chk({63'b0, cfgWr}, 64'd0, "R11 no strobe");
    winRd(8'h1D, 32'h0, "R11 entry write dropped");
    winWr(8'h00, 32'h0500_0000, 0);
    winRd(8'h00, 32'h0F00_0000, "R11 id write dropped");

    // R5 last entry
    winWr(8'h3F, 32'h1234_5678, 1);
    chk({59'b0, cfgIdx}, 64'd23, "R12 index last entry");
    winRd(8'h3F, 32'h1234_5678, "R5 entry23 high");
    chk(entries[23*64 +: 64], 64'h1234_5678_0001_0000, "R5 entry23 port");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule